// File: doc/BRIEF.md
# Register Bus Width Adapter

This block sits between a logical register client and a narrow peripheral port. The client asks for 16-bit or 32-bit register reads and writes, or for a 32-byte data-buffer burst. The adapter turns each request into a series of byte or halfword cycles on the downstream port. The port is 8 bits or 16 bits wide, chosen by a strap.

After reset the adapter brings the port up by itself. It writes the bus-mode register. On a 16-bit port it then reads that register back to learn the port's byte order. Last, it reads the version register to tell whether a device answers at all. Client requests are held off until this start-up sequence has finished.

Every downstream sub-access is held until the port acknowledges it. The client receives one completion pulse after the last sub-access, together with any read data.

Top module: `bus_width_adapter`

## Requirements
- R1: From reset release until `init_done` rises, `req_ready` stays low. While reset is asserted, `init_done`, `req_ready`, `bus_req` and `resp_valid` are all low. Once `init_done` rises it stays high.
- R2: Start-up begins with the bus-mode write. On an 8-bit port this is two byte writes of 0x00, to offset 0x00 and then to offset 0x01. On a 16-bit port it is one halfword write of 0x0101 to offset 0x00.
- R3: On a 16-bit port the mode write is followed by a halfword read of offset 0x00. A raw bus value of exactly 0x0001 sets `big_endian`=0, and any other value sets `big_endian`=1. On an 8-bit port there is no read-back, and `big_endian` is 0.
- R4: Start-up ends with a read of the version register at offset 0x16. On a 16-bit port this is one halfword read. On an 8-bit port it is a byte read of 0x16 (bits 7:0) followed by a byte read of 0x17 (bits 15:8). `dev_absent` is 1 exactly when the value read is 0x0000 or 0xFFFF.
- R5: On an 8-bit port, a 16-bit register access (`req_size`=0) becomes two byte cycles. Offset n carries bits 7:0 and comes first; offset n+1 carries bits 15:8. Bytes travel on `bus_wdata[7:0]` and `bus_rdata[7:0]`. `bus_wdata[15:8]` is 0, and `bus_rdata[15:8]` is ignored.
- R6: A 32-bit access (`req_size`=1) becomes two 16-bit accesses: offset n with bits 15:0 first, then offset n+2 with bits 31:16. On an 8-bit port this makes four byte cycles at n, n+1, n+2 and n+3.
- R7: On a 16-bit port, a register halfword appears on the bus unchanged when `big_endian`=0, and with its two bytes swapped when `big_endian`=1. This holds for both reads and writes.
- R8: A burst (`req_size`=2) moves the 32-byte buffer through the data port at offset 0x40, in ascending byte order. On an 8-bit port it is 32 byte cycles at 0x40 through 0x5F, with buffer byte i in cycle i. On a 16-bit port it is 16 halfword cycles, all at 0x40.
- R9: On a 16-bit port, beat k of a burst carries the logical halfword {byte 2k+1, byte 2k} of the buffer. This halfword is byte-swapped on the bus when `big_endian`=0 and sent unchanged when `big_endian`=1, which is the opposite of register accesses.
- R10: A sub-access keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until `bus_ack` is sampled high. The next sub-access starts only after that.
- R11: `resp_valid` is a one-cycle pulse in the cycle after the final acknowledge. It carries read data in `resp_rdata` (register reads, zero-extended) or `resp_bdata` (bursts). `req_ready` stays low while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wide | input | 1 | Port width strap, sampled at start-up: 1 = 16-bit, 0 = 8-bit |
| init_done | output | 1 | Start-up sequence finished |
| big_endian | output | 1 | Detected byte order of a 16-bit port |
| dev_absent | output | 1 | Version read returned 0x0000 or 0xFFFF |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Adapter accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = data burst |
| req_addr | input | 8 | Register offset (ignored for bursts) |
| req_wdata | input | 32 | Register write data |
| req_bdata | input | 256 | Burst write buffer, byte i at bits 8i+7:8i |
| resp_valid | output | 1 | Completion pulse |
| resp_rdata | output | 32 | Register read data |
| resp_bdata | output | 256 | Burst read buffer |
| bus_req | output | 1 | Downstream cycle request |
| bus_we | output | 1 | Downstream write |
| bus_addr | output | 8 | Downstream byte offset |
| bus_wdata | output | 16 | Downstream write lanes |
| bus_ack | input | 1 | Downstream acknowledge |
| bus_rdata | input | 16 | Downstream read lanes |

## Verification
The assertions guard the cycle-level discipline on every clock. A pending sub-access is held until it is acknowledged. Byte cycles on a narrow port step the offset by one, and halfword bursts stay on one address. Completion follows an acknowledge, `resp_valid` never lasts two cycles, and `init_done` never falls. The lane mapping cannot be checked by the assertions: byte order for registers versus the data port, the result of the probe, and the version-based absence flag. Only the bench scenarios show these. They run four start-ups (narrow, wide little-endian, wide big-endian with an absent device, narrow absent) and compare every bus cycle and every response against values computed from the requirements.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    typedef enum logic [1:0] {
        ACC_HALF  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_BURST = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        IN_MODE,
        IN_MODE_W,
        IN_PROBE,
        IN_PROBE_W,
        IN_VER,
        IN_VER_W,
        IN_DONE
    } init_st_e;

endpackage

// File: rtl/bwa_lane.sv
// Byte-lane steering for one 16-bit path: either straight or swapped.
module bwa_lane (
    input  logic        swap_en,
    input  logic [15:0] din,
    output logic [15:0] dout
);
    for (genvar l = 0; l < 2; l++) begin : g_lane
        assign dout[8*l +: 8] = swap_en ? din[8*(1-l) +: 8] : din[8*l +: 8];
    end
endmodule

// File: rtl/bwa_seq.sv
// Sub-access engine: walks one logical access as byte or halfword cycles.
module bwa_seq
    import bwa_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUF_BYTES = 32,
    parameter int DATA_OFS  = 'h40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wide,
    input  logic                    big_endian,
    input  logic                    start,
    input  logic                    cmd_write,
    input  acc_size_e               cmd_size,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [8*BUF_BYTES-1:0]  cmd_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [8*BUF_BYTES-1:0]  rdata,
    output logic                    bus_req,
    output logic                    bus_we,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [15:0]             bus_wdata,
    input  logic                    bus_ack,
    input  logic [15:0]             bus_rdata
);
    localparam int BUF_BITS = 8 * BUF_BYTES;
    localparam int CNT_W    = $clog2(BUF_BYTES);

    typedef struct packed {
        logic              run;
        logic              done;
        logic              wr;
        acc_size_e         size;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [BUF_BITS-1:0] wbuf;
        logic [BUF_BITS-1:0] rbuf;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [CNT_W-1:0]     last_idx;
    logic [CNT_W:0]       boff;
    logic                 is_burst;
    logic                 swap_en;
    logic [BUF_BITS+15:0] wext;
    logic [15:0]          tx_lg;
    logic [15:0]          tx_bus;
    logic [15:0]          rx_lg;

    assign is_burst = (st_q.size == ACC_BURST);
    assign boff     = wide ? {st_q.cnt, 1'b0} : {1'b0, st_q.cnt};
    // registers follow the detected order; the data port uses the opposite one
    assign swap_en  = wide & (is_burst ? ~big_endian : big_endian);
    assign wext     = {16'h0000, st_q.wbuf};
    assign tx_lg    = wext[8*int'(boff) +: 16];

    always_comb begin
        case (st_q.size)
            ACC_HALF:  last_idx = wide ? CNT_W'(0) : CNT_W'(1);
            ACC_WORD:  last_idx = wide ? CNT_W'(1) : CNT_W'(3);
            default:   last_idx = wide ? CNT_W'(BUF_BYTES/2 - 1) : CNT_W'(BUF_BYTES - 1);
        endcase
    end

    bwa_lane u_tx_lane (
        .swap_en (swap_en),
        .din     (tx_lg),
        .dout    (tx_bus)
    );

    bwa_lane u_rx_lane (
        .swap_en (swap_en),
        .din     (bus_rdata),
        .dout    (rx_lg)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.run) begin
            if (start) begin
                st_d.run  = 1'b1;
                st_d.wr   = cmd_write;
                st_d.size = cmd_size;
                st_d.base = cmd_addr;
                st_d.cnt  = '0;
                st_d.wbuf = cmd_wdata;
                st_d.rbuf = '0;
            end
        end else if (bus_ack) begin
            if (!st_q.wr) begin
                for (int j = 0; j < BUF_BYTES; j++) begin
                    if (j == int'(boff)) begin
                        st_d.rbuf[8*j +: 8] = rx_lg[7:0];
                    end
                    if (wide && (j == int'(boff) + 1)) begin
                        st_d.rbuf[8*j +: 8] = rx_lg[15:8];
                    end
                end
            end
            if (st_q.cnt == last_idx) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (is_burst) begin
            bus_addr = wide ? ADDR_W'(DATA_OFS) : ADDR_W'(DATA_OFS) + ADDR_W'(st_q.cnt);
        end else begin
            bus_addr = st_q.base + ADDR_W'(boff);
        end
    end

    assign bus_wdata = wide ? tx_bus : {8'h00, tx_lg[7:0]};
    assign bus_req   = st_q.run;
    assign bus_we    = st_q.wr;
    assign busy      = st_q.run;
    assign done      = st_q.done;
    assign rdata     = st_q.rbuf;

    // R10: an unacknowledged sub-access is held unchanged
    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R11: completion only directly after an acknowledged cycle
    assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_ack));

    // R5: byte cycles on a narrow port walk the offset upward by one
    assert_byte_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !wide && (st_q.cnt != last_idx)) |=> (bus_addr == $past(bus_addr) + 1'b1));

    // R8: halfword bursts keep a fixed data-port address
    assert_burst_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && wide && is_burst && (st_q.cnt != last_idx)) |=> $stable(bus_addr));

endmodule

// File: rtl/bwa_init.sv
// Start-up sequencer: bus-mode write, byte-order probe, version check.
module bwa_init
    import bwa_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int MODE_OFS = 'h00,
    parameter int VER_OFS  = 'h16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              seq_busy,
    input  logic              seq_done,
    input  logic [15:0]       seq_rdata,
    output logic              wide,
    output logic              big_endian,
    output logic              dev_absent,
    output logic              done,
    output logic              start,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [15:0]       cmd_wdata
);
    typedef struct packed {
        init_st_e st;
        logic     wide;
        logic     be;
        logic     absent;
    } ini_st_t;

    ini_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        start     = 1'b0;
        cmd_write = 1'b0;
        cmd_addr  = ADDR_W'(MODE_OFS);
        cmd_wdata = 16'h0000;
        case (s_q.st)
            IN_MODE: begin
                cmd_write = 1'b1;
                cmd_wdata = cfg_wide ? 16'h0101 : 16'h0000;
                if (!seq_busy) begin
                    start    = 1'b1;
                    s_d.wide = cfg_wide;
                    s_d.st   = IN_MODE_W;
                end
            end
            IN_MODE_W: begin
                if (seq_done) begin
                    s_d.st = s_q.wide ? IN_PROBE : IN_VER;
                end
            end
            IN_PROBE: begin
                if (!seq_busy) begin
                    start  = 1'b1;
                    s_d.st = IN_PROBE_W;
                end
            end
            IN_PROBE_W: begin
                if (seq_done) begin
                    s_d.be = (seq_rdata != 16'h0001);
                    s_d.st = IN_VER;
                end
            end
            IN_VER: begin
                cmd_addr = ADDR_W'(VER_OFS);
                if (!seq_busy) begin
                    start  = 1'b1;
                    s_d.st = IN_VER_W;
                end
            end
            IN_VER_W: begin
                cmd_addr = ADDR_W'(VER_OFS);
                if (seq_done) begin
                    s_d.absent = (seq_rdata == 16'h0000) || (seq_rdata == 16'hFFFF);
                    s_d.st     = IN_DONE;
                end
            end
            default: begin
                s_d.st = IN_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: IN_MODE, wide: 1'b0, be: 1'b0, absent: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wide       = s_q.wide;
    assign big_endian = s_q.be;
    assign dev_absent = s_q.absent;
    assign done       = (s_q.st == IN_DONE);

    // R1: once start-up completes it never reopens
    assert_init_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R3: a narrow port never reports big-endian order
    assert_narrow_le_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide) |-> !big_endian);

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUF_BYTES = 32,
    parameter int DATA_OFS  = 'h40,
    parameter int MODE_OFS  = 'h00,
    parameter int VER_OFS   = 'h16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wide,
    output logic                   init_done,
    output logic                   big_endian,
    output logic                   dev_absent,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [1:0]             req_size,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [31:0]            req_wdata,
    input  logic [8*BUF_BYTES-1:0] req_bdata,
    output logic                   resp_valid,
    output logic [31:0]            resp_rdata,
    output logic [8*BUF_BYTES-1:0] resp_bdata,
    output logic                   bus_req,
    output logic                   bus_we,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [15:0]            bus_wdata,
    input  logic                   bus_ack,
    input  logic [15:0]            bus_rdata
);
    localparam int BUF_BITS = 8 * BUF_BYTES;

    logic                wide;
    logic                seq_busy;
    logic                seq_done;
    logic [BUF_BITS-1:0] seq_rdata;
    logic                ini_start;
    logic                ini_write;
    logic [ADDR_W-1:0]   ini_addr;
    logic [15:0]         ini_wdata;

    logic                seq_start;
    logic                cmd_write;
    acc_size_e           cmd_size;
    logic [ADDR_W-1:0]   cmd_addr;
    logic [BUF_BITS-1:0] cmd_wdata;

    bwa_init #(
        .ADDR_W   (ADDR_W),
        .MODE_OFS (MODE_OFS),
        .VER_OFS  (VER_OFS)
    ) u_init (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wide   (cfg_wide),
        .seq_busy   (seq_busy),
        .seq_done   (seq_done),
        .seq_rdata  (seq_rdata[15:0]),
        .wide       (wide),
        .big_endian (big_endian),
        .dev_absent (dev_absent),
        .done       (init_done),
        .start      (ini_start),
        .cmd_write  (ini_write),
        .cmd_addr   (ini_addr),
        .cmd_wdata  (ini_wdata)
    );

    assign req_ready = init_done && !seq_busy;

    always_comb begin
        if (init_done) begin
            seq_start = req_valid && req_ready;
            cmd_write = req_write;
            cmd_size  = acc_size_e'(req_size);
            cmd_addr  = req_addr;
            cmd_wdata = (req_size == 2'd2) ? req_bdata : BUF_BITS'(req_wdata);
        end else begin
            seq_start = ini_start;
            cmd_write = ini_write;
            cmd_size  = ACC_HALF;
            cmd_addr  = ini_addr;
            cmd_wdata = BUF_BITS'(ini_wdata);
        end
    end

    bwa_seq #(
        .ADDR_W    (ADDR_W),
        .BUF_BYTES (BUF_BYTES),
        .DATA_OFS  (DATA_OFS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide       (wide),
        .big_endian (big_endian),
        .start      (seq_start),
        .cmd_write  (cmd_write),
        .cmd_size   (cmd_size),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .busy       (seq_busy),
        .done       (seq_done),
        .rdata      (seq_rdata),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata)
    );

    assign resp_valid = seq_done && init_done;
    assign resp_rdata = seq_rdata[31:0];
    assign resp_bdata = seq_rdata;

    // R11: completion is a single-cycle pulse
    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

endmodule

// File: tb/bus_width_adapter_tb.sv
`timescale 1ns/1ps
module bus_width_adapter_tb;

    typedef struct {
        bit        we;
        bit [7:0]  addr;
        bit [15:0] wd;
        bit [15:0] mask;
        string     tag;
    } bus_item_t;

    typedef struct {
        bit         chk;
        bit         burst;
        bit [31:0]  rd;
        bit [255:0] bd;
        string      tag;
    } resp_item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wide = 1'b0;
    logic         init_done, big_endian, dev_absent;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [1:0]   req_size = 2'd0;
    logic [7:0]   req_addr = 8'h00;
    logic [31:0]  req_wdata = 32'h0;
    logic [255:0] req_bdata = '0;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic [255:0] resp_bdata;
    logic         bus_req, bus_we;
    logic [7:0]   bus_addr;
    logic [15:0]  bus_wdata;
    logic         bus_ack = 1'b0;
    logic [15:0]  bus_rdata = 16'h0;

    bus_width_adapter u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_wide (cfg_wide),
        .init_done (init_done), .big_endian (big_endian), .dev_absent (dev_absent),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_size (req_size), .req_addr (req_addr), .req_wdata (req_wdata),
        .req_bdata (req_bdata), .resp_valid (resp_valid), .resp_rdata (resp_rdata),
        .resp_bdata (resp_bdata), .bus_req (bus_req), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_ack (bus_ack),
        .bus_rdata (bus_rdata)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_ack = -10;
    int wcnt = 0;
    int lat = 0;
    bit wide_m = 0;
    bit be_m = 0;
    bit done_flag = 0;

    bus_item_t  exp_bus[$];
    resp_item_t exp_resp[$];
    bit [15:0]  rd_q[$];

    task automatic check(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit [15:0] swp(bit [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic push_bus(bit we, bit [7:0] a, bit [15:0] wd, bit [15:0] m, string tag);
        bus_item_t it;
        it.we = we; it.addr = a; it.wd = wd & m; it.mask = m; it.tag = tag;
        exp_bus.push_back(it);
    endtask

    // bus responder, bus-cycle monitor and response monitor
    always @(negedge clk) begin
        bus_item_t  it;
        resp_item_t r;
        cyc++;
        if (!rst_n) begin
            bus_ack = 1'b0;
            wcnt = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wcnt < lat) begin
                wcnt++;
            end else begin
                wcnt = 0;
                if (exp_bus.size() == 0) begin
                    check(1'b0, "R10", "unexpected bus cycle", {bus_we, bus_addr}, 0);
                end else begin
                    it = exp_bus.pop_front();
                    check(bus_we == it.we && bus_addr == it.addr, it.tag, "bus cycle we/addr",
                          {bus_we, bus_addr}, {it.we, it.addr});
                    if (it.we)
                        check((bus_wdata & it.mask) == it.wd, it.tag, "bus write data",
                              bus_wdata, it.wd);
                end
                if (!bus_we) bus_rdata = (rd_q.size() != 0) ? rd_q.pop_front() : 16'hDEAD;
                bus_ack = 1'b1;
                last_ack = cyc;
            end
        end
        if (rst_n && resp_valid) begin
            if (exp_resp.size() == 0) begin
                check(1'b0, "R11", "unexpected response", 1, 0);
            end else begin
                r = exp_resp.pop_front();
                check(cyc == last_ack + 1, "R11", "response timing", cyc, last_ack + 1);
                if (r.chk && r.burst) check(resp_bdata == r.bd, r.tag, "burst read data", resp_bdata, r.bd);
                if (r.chk && !r.burst) check(resp_rdata == r.rd, r.tag, "register read data", resp_rdata, r.rd);
            end
        end
    end

    task automatic drive(bit wr, bit [1:0] sz, bit [7:0] a, bit [31:0] wd, bit [255:0] bd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wd; req_bdata = bd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R11", "ready low while busy", req_ready, 0);
        while (exp_resp.size() != 0) @(negedge clk);
        @(negedge clk);
        check(exp_bus.size() == 0, "R10", "all sub-accesses completed", exp_bus.size(), 0);
    endtask

    task automatic reg_access(bit wr, bit [1:0] sz, bit [7:0] a, bit [31:0] wd, bit [15:0] seed, string tag);
        resp_item_t r;
        bit [31:0] res = 0;
        if (wide_m) begin
            for (int i = 0; i < ((sz == 2'd1) ? 2 : 1); i++) begin
                bit [15:0] lg = wd[16*i +: 16];
                bit [15:0] raw = seed + 16'(i) * 16'h1357;
                push_bus(wr, a + 8'(2*i), be_m ? swp(lg) : lg, 16'hFFFF, tag);
                if (!wr) begin
                    rd_q.push_back(raw);
                    res[16*i +: 16] = be_m ? swp(raw) : raw;
                end
            end
        end else begin
            for (int i = 0; i < ((sz == 2'd1) ? 4 : 2); i++) begin
                bit [15:0] raw = {8'hC3, seed[7:0] + 8'(i) * 8'h11};
                push_bus(wr, a + 8'(i), {8'h00, wd[8*i +: 8]}, 16'hFFFF, tag);
                if (!wr) begin
                    rd_q.push_back(raw);
                    res[8*i +: 8] = raw[7:0];
                end
            end
        end
        r.chk = !wr; r.burst = 0; r.rd = res; r.bd = '0; r.tag = tag;
        exp_resp.push_back(r);
        drive(wr, sz, a, wd, '0);
    endtask

    task automatic burst_access(bit wr, bit [255:0] bd, bit [15:0] seed, string tag);
        resp_item_t r;
        bit [255:0] res = '0;
        if (wide_m) begin
            for (int k = 0; k < 16; k++) begin
                bit [15:0] h = bd[16*k +: 16];
                bit [15:0] raw = seed ^ (16'(k) * 16'h0F1E);
                push_bus(wr, 8'h40, be_m ? h : swp(h), 16'hFFFF, tag);
                if (!wr) begin
                    rd_q.push_back(raw);
                    res[16*k +: 16] = be_m ? raw : swp(raw);
                end
            end
        end else begin
            for (int i = 0; i < 32; i++) begin
                bit [15:0] raw = {8'h5C, seed[7:0] + 8'(i) * 8'h05};
                push_bus(wr, 8'h40 + 8'(i), {8'h00, bd[8*i +: 8]}, 16'hFFFF, tag);
                if (!wr) begin
                    rd_q.push_back(raw);
                    res[8*i +: 8] = raw[7:0];
                end
            end
        end
        r.chk = !wr; r.burst = 1; r.rd = 0; r.bd = res; r.tag = tag;
        exp_resp.push_back(r);
        drive(wr, 2'd2, 8'h00, 0, bd);
    endtask

    task automatic start_up(bit w, int l, bit [15:0] probe_raw, bit [15:0] ver_raw);
        bit [15:0] ver_lg;
        bit exp_absent;
        @(negedge clk);
        rst_n = 1'b0;
        exp_bus.delete(); exp_resp.delete(); rd_q.delete();
        cfg_wide = w; lat = l; wide_m = w;
        be_m = w ? (probe_raw != 16'h0001) : 1'b0;
        if (w) begin
            push_bus(1, 8'h00, 16'h0101, 16'hFFFF, "R2");
            push_bus(0, 8'h00, 16'h0000, 16'hFFFF, "R3");
            push_bus(0, 8'h16, 16'h0000, 16'hFFFF, "R4");
            rd_q.push_back(probe_raw);
            rd_q.push_back(ver_raw);
            ver_lg = be_m ? swp(ver_raw) : ver_raw;
        end else begin
            push_bus(1, 8'h00, 16'h0000, 16'hFFFF, "R2");
            push_bus(1, 8'h01, 16'h0000, 16'hFFFF, "R2");
            push_bus(0, 8'h16, 16'h0000, 16'hFFFF, "R4");
            push_bus(0, 8'h17, 16'h0000, 16'hFFFF, "R4");
            rd_q.push_back({8'hC3, ver_raw[7:0]});
            rd_q.push_back({8'hC3, ver_raw[15:8]});
            ver_lg = ver_raw;
        end
        exp_absent = (ver_lg == 16'h0000) || (ver_lg == 16'hFFFF);
        repeat (3) @(negedge clk);
        check(!init_done && !req_ready && !bus_req && !resp_valid, "R1", "reset state",
              {init_done, req_ready, bus_req, resp_valid}, 0);
        rst_n = 1'b1;
        while (!init_done) begin
            @(negedge clk);
            if (!init_done) check(!req_ready, "R1", "ready gated during start-up", req_ready, 0);
        end
        check(exp_bus.size() == 0, "R2", "start-up cycles all seen", exp_bus.size(), 0);
        check(big_endian == be_m, "R3", "detected byte order", big_endian, be_m);
        check(dev_absent == exp_absent, "R4", "device absent flag", dev_absent, exp_absent);
        check(exp_resp.size() == 0, "R11", "no response for start-up", exp_resp.size(), 0);
        repeat (2) @(negedge clk);
        check(init_done, "R1", "start-up stays complete", init_done, 1);
    endtask

    initial begin
        bit [255:0] pat;
        for (int i = 0; i < 32; i++) pat[8*i +: 8] = 8'(i * 7 + 3);

        // narrow port, device present
        start_up(1'b0, 0, 16'h0000, 16'h1234);
        reg_access(1, 2'd0, 8'h10, 32'h0000BEEF, 16'h0, "R5");
        reg_access(0, 2'd0, 8'h30, 0, 16'h00A5, "R5");
        reg_access(1, 2'd1, 8'h20, 32'h11223344, 16'h0, "R6");
        reg_access(0, 2'd1, 8'h24, 0, 16'h0012, "R6");
        burst_access(1, pat, 16'h0, "R8");
        burst_access(0, '0, 16'h0033, "R8");

        // wide port, little-endian probe
        start_up(1'b1, 2, 16'h0001, 16'h0203);
        reg_access(1, 2'd0, 8'h18, 32'h0000CAFE, 16'h0, "R7");
        reg_access(1, 2'd1, 8'h10, 32'hA1B2C3D4, 16'h0, "R6");
        reg_access(0, 2'd1, 8'h04, 0, 16'h8421, "R7");
        burst_access(1, pat, 16'h0, "R9");
        burst_access(0, '0, 16'h7E81, "R9");

        // wide port, big-endian probe, version reads all ones
        start_up(1'b1, 1, 16'h0100, 16'hFFFF);
        reg_access(1, 2'd0, 8'h18, 32'h0000CAFE, 16'h0, "R7");
        reg_access(0, 2'd0, 8'h1C, 0, 16'h1F20, "R7");
        reg_access(0, 2'd1, 8'h10, 0, 16'h4455, "R6");
        burst_access(1, ~pat, 16'h0, "R9");
        burst_access(0, '0, 16'h0F0F, "R8");

        // narrow port, version reads zero
        start_up(1'b0, 0, 16'h0000, 16'h0000);
        reg_access(0, 2'd0, 8'h02, 0, 16'h0077, "R5");

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_vec++;
            n_bad++;
            $display("FAIL R10 watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule